// File: doc/BRIEF.md
# Pending-Interrupt Flag Register with Set and Clear Ports

This block holds one sticky pending flag per interrupt source of a small 8-bit system. A source such as a timer or a serial channel pulses its event line for one clock; if that source's enable input is high, its flag is raised and stays raised until software clears it. One level-sensitive request line, `irq`, is high while any flag is raised. A single registered signal drives it, so it follows the flags one clock later.

Software reaches the flags through two bus addresses that both read back the same pending byte. A write to the clear port drops exactly the flags whose data bits are 1. A write to the set port raises the flags whose data bits are 1, which lets software inject a request. The usual service loop reads the byte and writes the same value back to the clear port. This acknowledges only the flags it is about to handle. A flag that fires again after the acknowledge is raised once more, so the request returns.

Top module: `pend_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, the pending byte on `bus_rdata` is 0x00 and `irq` is 0.
- R2: `bus_rdata` shows the pending byte whatever the value of `bus_addr`. Address 0 is the set port and address 1 is the clear port, and both return the same byte.
- R3: A write (`bus_sel`=1, `bus_we`=1) to address 1 clears exactly the flags whose `bus_wdata` bit is 1 at the next clock and leaves every other flag as it was.
- R4: A write to address 0 raises every flag whose `bus_wdata` bit is 1 at the next clock. A nonzero value therefore forces a request.
- R5: `irq` is 1 one clock after the pending byte becomes nonzero. It returns to 0 one clock after every flag is 0.
- R6: Writing 0xFF to address 1 clears all flags. `irq` then stays 0 until a new event or set write arrives.
- R7: An enabled event on a source whose flag was just cleared raises the flag again, and `irq` reasserts.
- R8: When `src_enable[i]` is 0, an event on `src_event[i]` leaves flag i unchanged. Dropping the enable does not clear a flag that is already pending.
- R9: If an enabled event and a clear-port write hit the same flag in the same clock, the flag is 1 afterwards.
- R10: A one-clock pulse on `src_event[i]` with `src_enable[i]`=1 raises flag i at the next clock. The flag stays 1 after the pulse ends.
- R11: A bus cycle with `bus_sel`=0 or `bus_we`=0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Block selected by the address decoder |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = set port, 1 = clear port |
| bus_wdata | input | 8 | Write data, one bit per source |
| bus_rdata | output | 8 | Pending byte |
| src_event | input | 8 | One-clock event pulses from the sources |
| src_enable | input | 8 | Per-source enable for event capture |
| irq | output | 1 | Level interrupt request |

## Verification
The bench aims at the same-clock collision of an event and a clear of one flag. A design where the clear wins would silently lose that event. It clears one flag while others are pending, to catch a clear port that wipes the whole byte or leaves the wrong bit. It drops an enable with the flag already pending, which exposes a design that gates the stored flag rather than the incoming event. It also times `irq` to the exact clock after the byte turns nonzero and after it turns zero, and probes unselected or read-only bus cycles that must leave every flag alone.

// File: rtl/pid_pkg.sv
package pid_pkg;

  typedef enum logic {
    PORT_SET = 1'b0,
    PORT_CLR = 1'b1
  } port_e;

  // Next value of one flag: an event or a set write wins over a clear.
  function automatic logic flag_next(input logic cur, input logic hit,
                                     input logic setb, input logic clrb);
    return hit | setb | (cur & ~clrb);
  endfunction

  // Masking helper used by the write decoder.
  function automatic logic [7:0] mask_if(input logic cond, input logic [7:0] d);
    return cond ? d : 8'h00;
  endfunction

endpackage

// File: rtl/pid_wr_decode.sv
module pid_wr_decode
  import pid_pkg::*;
#(
  parameter int SRC_N = 8
) (
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [SRC_N-1:0] bus_wdata,
  output logic [SRC_N-1:0] set_mask,
  output logic [SRC_N-1:0] clr_mask
);

  logic wr_stb;

  assign wr_stb = bus_sel & bus_we;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (wr_stb) begin
      if (port_e'(bus_addr) == PORT_SET) set_mask = bus_wdata;
      else                               clr_mask = bus_wdata;
    end
  end

endmodule

// File: rtl/pid_src_gate.sv
module pid_src_gate #(
  parameter int SRC_N = 8
) (
  input  logic [SRC_N-1:0] src_event,
  input  logic [SRC_N-1:0] src_enable,
  output logic [SRC_N-1:0] ev_hit
);

  for (genvar g = 0; g < SRC_N; g++) begin : g_gate
    assign ev_hit[g] = src_event[g] & src_enable[g];
  end

endmodule

// File: rtl/pid_pend_bit.sv
module pid_pend_bit
  import pid_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic setb,
  input  logic clrb,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= flag_next(q, hit, setb, clrb);
  end

endmodule

// File: rtl/pid_irq_reg.sv
module pid_irq_reg #(
  parameter int SRC_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] pend,
  output logic             irq
);

  logic any_pend;

  assign any_pend = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_pend;
  end

endmodule

// File: rtl/pend_irq_ctrl.sv
module pend_irq_ctrl #(
  parameter int SRC_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [SRC_N-1:0] bus_wdata,
  output logic [SRC_N-1:0] bus_rdata,
  input  logic [SRC_N-1:0] src_event,
  input  logic [SRC_N-1:0] src_enable,
  output logic             irq
);

  // Named internal events, visible to the bound checker.
  logic [SRC_N-1:0] ev_hit;
  logic [SRC_N-1:0] set_mask;
  logic [SRC_N-1:0] clr_mask;
  logic [SRC_N-1:0] pend_q;

  pid_src_gate #(.SRC_N(SRC_N)) u_gate (
    .src_event (src_event),
    .src_enable(src_enable),
    .ev_hit    (ev_hit)
  );

  pid_wr_decode #(.SRC_N(SRC_N)) u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .set_mask (set_mask),
    .clr_mask (clr_mask)
  );

  for (genvar g = 0; g < SRC_N; g++) begin : g_flag
    pid_pend_bit u_bit (
      .clk  (clk),
      .rst_n(rst_n),
      .hit  (ev_hit[g]),
      .setb (set_mask[g]),
      .clrb (clr_mask[g]),
      .q    (pend_q[g])
    );
  end

  pid_irq_reg #(.SRC_N(SRC_N)) u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (pend_q),
    .irq  (irq)
  );

  // Both ports read the same byte.
  assign bus_rdata = pend_q;

endmodule

// File: rtl/pid_checker.sv
module pid_checker #(
  parameter int SRC_N = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_N-1:0] pend,
  input logic [SRC_N-1:0] ev_hit,
  input logic [SRC_N-1:0] set_mask,
  input logic [SRC_N-1:0] clr_mask,
  input logic             irq
);

  // High once the previous clock was already out of reset.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R3: a cleared flag with no competing event or set is low next clock
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((pend & $past(clr_mask & ~ev_hit & ~set_mask)) == '0));

  // R4: a set write raises its flags
  a_r4_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((pend & $past(set_mask)) == $past(set_mask)));

  // R5: irq follows the pending byte one clock later
  a_r5_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (irq == ($past(pend) != '0)));

  // R8: a flag only falls through a clear write
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(pend) & ~$past(clr_mask) & ~pend) == '0));

  // R9: an enabled event is never lost, even against a clear
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(ev_hit) & ~pend) == '0));

  // R11: a flag only rises through an enabled event or a set write
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((pend & ~$past(pend) & ~$past(ev_hit) & ~$past(set_mask)) == '0));

endmodule

bind pend_irq_ctrl pid_checker #(.SRC_N(SRC_N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pend    (pend_q),
  .ev_hit  (ev_hit),
  .set_mask(set_mask),
  .clr_mask(clr_mask),
  .irq     (irq)
);

// File: tb/test_pend_irq_ctrl.sv
module test_pend_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] src_event = 8'h00;
  logic [7:0] src_enable = 8'hFF;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] pend;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t sb[$];

  logic [7:0] m_pend = 8'h00;
  logic       m_irq = 1'b0;

  always #10 clk = ~clk;

  pend_irq_ctrl i_pend_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_event(src_event), .src_enable(src_enable), .irq(irq)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one clock of stimulus, expected result pushed to the scoreboard.
  task automatic step(input logic sel, input logic we, input logic addr,
                      input logic [7:0] wd, input logic [7:0] ev,
                      input logic [7:0] en, input string tag);
    logic [7:0] setm, clrm, hit;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = addr; bus_wdata = wd;
    src_event = ev; src_enable = en;
    setm = (sel && we && !addr) ? wd : 8'h00;
    clrm = (sel && we && addr) ? wd : 8'h00;
    hit  = ev & en;
    @(posedge clk);
    m_irq  = (m_pend != 8'h00);
    m_pend = (m_pend & ~clrm) | setm | hit;
    sb.push_back('{m_pend, m_irq, tag});
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hFF, tag);
  endtask

  // Monitor: compare outputs shortly after each edge.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check8({e.tag, " pend"}, bus_rdata, e.pend);
      check8({e.tag, " irq"}, {7'b0, irq}, {7'b0, e.irq});
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check8("R1 reset pend", bus_rdata, 8'h00);
    check8("R1 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;

    // R10 / R5: event raises a sticky flag; irq one clock later
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h01, 8'hFF, "R10 event sets bit0");
    idle("R5 irq after pending");
    idle("R10 flag sticky");

    // R2: both addresses read the same byte
    @(negedge clk);
    bus_addr = 1'b0; #1;
    check8("R2 read set port", bus_rdata, 8'h01);
    bus_addr = 1'b1; #1;
    check8("R2 read clear port", bus_rdata, 8'h01);

    // R4 set write, R3 partial clear
    step(1'b1, 1'b1, 1'b0, 8'hA0, 8'h00, 8'hFF, "R4 set write A0");
    step(1'b1, 1'b1, 1'b1, 8'h21, 8'h00, 8'hFF, "R3 clear 21");
    idle("R3 others kept");

    // R11: unselected or read cycles change nothing
    step(1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 8'hFF, "R11 sel low");
    step(1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, 8'hFF, "R11 we low");
    step(1'b0, 1'b1, 1'b0, 8'h0F, 8'h00, 8'hFF, "R11 set sel low");

    // R6: clear all, irq falls and stays low
    step(1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 8'hFF, "R6 clear FF");
    idle("R6 irq falls");
    idle("R6 stays quiet");
    idle("R6 stays quiet 2");

    // R7: re-fire after clear
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h08, 8'hFF, "R7 event bit3");
    step(1'b1, 1'b1, 1'b1, 8'h08, 8'h00, 8'hFF, "R7 ack bit3");
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h08, 8'hFF, "R7 event bit3 again");
    idle("R7 irq reasserts");

    // R8: disabled source blocked; pending flag kept when enable drops
    step(1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 8'hFF, "R8 prep clear");
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h20, 8'hDF, "R8 disabled event");
    idle("R8 still clear");
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h20, 8'hFF, "R8 enabled event");
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hDF, "R8 enable dropped");
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, "R8 all disabled");

    // R9: event and clear collide on bit2
    step(1'b1, 1'b1, 1'b1, 8'h24, 8'h04, 8'hFF, "R9 event beats clear");
    idle("R9 bit2 held");

    step(1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 8'hFF, "R6 final clear");
    idle("R5 irq low at end");
    idle("R5 idle end");
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule